// File: doc/BRIEF.md
# Standby DRAM Refresh Timebase Controller

This block decides when a DRAM refresh request is issued, and from which clock that timing comes. While the system is powered, each tick from the fast interval timer produces one request. If power is lost and standby refresh is enabled, timing moves to a free-running 32.768 kHz slow clock. A programmable interval on that clock sets the refresh rate. After power returns, timing moves back to the fast timer. The controller also selects the refresh type that goes with each request: either CAS-before-RAS or RAS-only.

A small configuration register holds the refresh type, the standby enable and the standby interval. The register keeps its contents when power-good drops. It is cleared only when the power-sense input is also low. Power-good, power-sense and the slow clock reach the block asynchronously, and each passes through two flops. A slow-clock watchdog handles a recovery that stalls. If no fast tick arrives after power returns, it removes standby and hands timing back to the fast timebase.

Top module: `stby_refresh_ctrl`

## Requirements
- R1: After reset, with power-good high, the register reads 0x00. No request is issued, timebase status is 0 and the power-down flag is 0.
- R2: While power-good is high, a write loads bits 7:4. Bit 3 always reads the timebase status and bits 2:0 always read 0. A write while power-good is low has no effect.
- R3: In normal operation each fast tick yields one request. ref_cbr_o carries bit 7 of the register with the request: 1 means CAS-before-RAS, 0 means RAS-only.
- R4: If power-good is low and bit 6 (standby enable) is 0, the power-down flag is set and no request is issued, even when fast ticks arrive.
- R5: If power-good is low and bit 6 is 1, fast ticks keep producing requests until the first edge of the slow clock. Only then are the power-down flag and timebase status (bit 3) set.
- R6: In standby, bits 5:4 set the request rate. 00 gives a request on every slow-clock edge, which is two per slow cycle. 01, 10 and 11 give one request per 2, 4 and 8 slow-clock rising edges.
- R7: Bits 7:4 keep their values while power-good is low, as long as power-sense is high. Power-sense low together with power-good low clears them and stops standby refresh.
- R8: After power-good returns, the slow timebase stays active until the next fast tick. During that time requests come on every slow-clock edge, whatever bits 5:4 say. The fast tick itself issues a request and clears the status bit.
- R9: If the slow timebase is held with power-good high for 64 slow-clock rising edges without a fast tick, bit 6 is cleared and the fast timebase resumes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pwr_good_i | input | 1 | Power-good, asynchronous |
| pwr_sense_i | input | 1 | Power-sense, asynchronous; low with power-good low clears the register |
| slow_clk_i | input | 1 | 32.768 kHz clock, asynchronous |
| fast_tick_i | input | 1 | One-cycle refresh tick from the interval timer |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_wdata_i | input | 8 | Register write data |
| cfg_rdata_o | output | 8 | Register read value |
| ref_req_o | output | 1 | One-cycle refresh request |
| ref_cbr_o | output | 1 | Refresh type with the request, 1 = CAS-before-RAS |
| tb_slow_o | output | 1 | Timebase status, 1 = slow clock |
| pd_active_o | output | 1 | Power-down in effect |

## Verification
The checker tests several rules on every cycle:
- A power-down without standby issues no request.
- The slow timebase is entered only when the power-down flag is set.
- The slow timebase is left only after a fast tick or after standby has been cleared.
- The register is stable unless a write, the watchdog or the sense clear acts on it.
- The request type follows bit 7.

Other behaviours depend on real time, and only the bench scenarios show them:
- the request rate for each interval code;
- the hand-over delay until the first slow edge;
- the full-rate recovery window;
- the 64-edge watchdog expiry.

// File: rtl/stby_ref_pkg.sv
package stby_ref_pkg;
  localparam int CFG_W    = 8;
  localparam int IVL_W    = 2;
  localparam int CBR_BIT  = 7;
  localparam int STBY_BIT = 6;
  localparam int IVL_LO   = 4;
  localparam int TB_BIT   = 3;

  typedef struct packed {
    logic             cbr;
    logic             stby_en;
    logic [IVL_W-1:0] ivl;
  } ref_cfg_t;

  localparam ref_cfg_t CFG_DEFAULT = '0;

  typedef enum logic [2:0] {
    ST_RUN,    // powered, fast timebase
    ST_ENTER,  // power lost, waiting for first slow edge
    ST_STBY,   // powered down, slow timebase
    ST_RECOV,  // powered, still on slow timebase
    ST_OFF     // powered down, no refresh
  } tb_state_e;
endpackage

// File: rtl/stby_sync.sv
module stby_sync #(
  parameter int           W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/stby_slow_div.sv
module stby_slow_div #(
  parameter int IVL_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sc_i,
  input  logic             run_i,
  input  logic             full_rate_i,
  input  logic [IVL_W-1:0] ivl_i,
  output logic             rise_o,
  output logic             fall_o,
  output logic             tick_o
);
  localparam int CNT_W = (1 << IVL_W) - 1;

  logic             sc_q;
  logic [CNT_W-1:0] cnt_q, lim_m1;
  logic             wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sc_q <= 1'b0;
    else         sc_q <= sc_i;
  end

  assign rise_o = sc_i & ~sc_q;
  assign fall_o = ~sc_i & sc_q;
  assign lim_m1 = CNT_W'((32'd1 << ivl_i) - 32'd1);
  assign wrap   = (cnt_q == lim_m1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (rise_o)  cnt_q <= wrap ? '0 : cnt_q + 1'b1;
  end

  // ivl==0 and recovery both run at the half-cycle rate
  assign tick_o = (full_rate_i || ivl_i == '0) ? (rise_o | fall_o)
                                               : (rise_o & wrap);
endmodule

// File: rtl/stby_watchdog.sv
module stby_watchdog #(
  parameter int LIMIT = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic kick_i,
  output logic expire_o
);
  localparam int CNT_W = (LIMIT > 2) ? $clog2(LIMIT) : 1;

  logic [CNT_W-1:0] cnt_q;
  logic             last;

  assign last     = (cnt_q == CNT_W'(LIMIT - 1));
  assign expire_o = arm_i & kick_i & last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!arm_i || expire_o) cnt_q <= '0;
    else if (kick_i)            cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/stby_cfg_reg.sv
module stby_cfg_reg
  import stby_ref_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pg_i,
  input  logic             ps_i,
  input  logic             we_i,
  input  logic [CFG_W-1:0] wdata_i,
  input  logic             wd_clr_i,
  output ref_cfg_t         cfg_o
);
  ref_cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= CFG_DEFAULT;
    end else if (!pg_i && !ps_i) begin
      cfg_q <= CFG_DEFAULT;
    end else begin
      if (we_i && pg_i) begin
        cfg_q.cbr     <= wdata_i[CBR_BIT];
        cfg_q.stby_en <= wdata_i[STBY_BIT];
        cfg_q.ivl     <= wdata_i[IVL_LO +: IVL_W];
      end
      if (wd_clr_i) cfg_q.stby_en <= 1'b0;
    end
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/stby_refresh_ctrl.sv
module stby_refresh_ctrl
  import stby_ref_pkg::*;
#(
  parameter int WD_LIMIT = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pwr_good_i,
  input  logic             pwr_sense_i,
  input  logic             slow_clk_i,
  input  logic             fast_tick_i,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  output logic [CFG_W-1:0] cfg_rdata_o,
  output logic             ref_req_o,
  output logic             ref_cbr_o,
  output logic             tb_slow_o,
  output logic             pd_active_o
);
  logic [2:0] async_s;
  logic       pg_s, ps_s, sc_s;
  logic       sc_rise, sc_fall, div_tick, wd_expire;
  ref_cfg_t   cfg;
  tb_state_e  state_q, state_d;
  logic       req_d, ref_q, cbr_q;

  // {slow clock, sense, power-good}; sense resets high so reset never clears cfg
  stby_sync #(.W(3), .RST_VAL(3'b010)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({slow_clk_i, pwr_sense_i, pwr_good_i}),
    .q_o   (async_s)
  );
  assign {sc_s, ps_s, pg_s} = async_s;

  stby_cfg_reg u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pg_i    (pg_s),
    .ps_i    (ps_s),
    .we_i    (cfg_we_i),
    .wdata_i (cfg_wdata_i),
    .wd_clr_i(wd_expire),
    .cfg_o   (cfg)
  );

  stby_slow_div #(.IVL_W(IVL_W)) u_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sc_i       (sc_s),
    .run_i      (state_q == ST_STBY),
    .full_rate_i(state_q == ST_RECOV),
    .ivl_i      (cfg.ivl),
    .rise_o     (sc_rise),
    .fall_o     (sc_fall),
    .tick_o     (div_tick)
  );

  stby_watchdog #(.LIMIT(WD_LIMIT)) u_wd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .arm_i   (state_q == ST_RECOV),
    .kick_i  (sc_rise),
    .expire_o(wd_expire)
  );

  always_comb begin
    state_d = state_q;
    req_d   = 1'b0;
    unique case (state_q)
      ST_RUN: begin
        req_d = fast_tick_i;
        if (!pg_s) state_d = cfg.stby_en ? ST_ENTER : ST_OFF;
      end
      ST_ENTER: begin
        req_d = fast_tick_i | sc_rise | sc_fall;
        if (pg_s)                     state_d = ST_RUN;
        else if (!cfg.stby_en)        state_d = ST_OFF;
        else if (sc_rise || sc_fall)  state_d = ST_STBY;
      end
      ST_STBY: begin
        req_d = div_tick;
        if (!cfg.stby_en) state_d = ST_OFF;
        else if (pg_s)    state_d = ST_RECOV;
      end
      ST_RECOV: begin
        req_d = fast_tick_i | div_tick;
        if (fast_tick_i || wd_expire) state_d = ST_RUN;
        else if (!pg_s)               state_d = ST_STBY;
      end
      ST_OFF: begin
        if (pg_s) state_d = ST_RUN;
      end
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RUN;
      ref_q   <= 1'b0;
      cbr_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      ref_q   <= req_d;
      cbr_q   <= cfg.cbr;
    end
  end

  assign tb_slow_o   = (state_q == ST_STBY) || (state_q == ST_RECOV);
  assign pd_active_o = (state_q == ST_STBY) || (state_q == ST_OFF);
  assign ref_req_o   = ref_q;
  assign ref_cbr_o   = cbr_q;
  assign cfg_rdata_o = {cfg.cbr, cfg.stby_en, cfg.ivl, tb_slow_o, 3'b000};
endmodule

// File: rtl/stby_refresh_chk.sv
module stby_refresh_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       fast_tick_i,
  input logic       cfg_we_i,
  input logic [7:0] cfg_rdata_o,
  input logic       ref_req_o,
  input logic       ref_cbr_o,
  input logic       tb_slow_o,
  input logic       pd_active_o,
  input logic       pg_s,
  input logic       ps_s,
  input logic       wd_expire
);
  a_r4_off_no_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pd_active_o && !tb_slow_o) |=> !ref_req_o);

  a_r5_slow_needs_pd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tb_slow_o) |-> pd_active_o);

  a_r5_pd_after_slow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(pd_active_o) && cfg_rdata_o[6]) |-> tb_slow_o);

  a_r8_leave_slow_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tb_slow_o) |-> ($past(fast_tick_i) || !cfg_rdata_o[6]));

  a_r7_cfg_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(cfg_we_i && pg_s) && !wd_expire && (pg_s || ps_s))
      |=> $stable(cfg_rdata_o[7:4]));

  a_r3_type_follows_cfg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_req_o |-> (ref_cbr_o == $past(cfg_rdata_o[7])));
endmodule

bind stby_refresh_ctrl stby_refresh_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .fast_tick_i(fast_tick_i),
  .cfg_we_i   (cfg_we_i),
  .cfg_rdata_o(cfg_rdata_o),
  .ref_req_o  (ref_req_o),
  .ref_cbr_o  (ref_cbr_o),
  .tb_slow_o  (tb_slow_o),
  .pd_active_o(pd_active_o),
  .pg_s       (pg_s),
  .ps_s       (ps_s),
  .wd_expire  (wd_expire)
);

// File: tb/sim_stby_refresh_ctrl.sv
`timescale 1ns/1ps
module sim_stby_refresh_ctrl;
  localparam int SLOW_HALF = 20;
  localparam int FT_PER    = 30;
  localparam int NVEC      = 7;
  // {expected standby requests over 16 slow cycles, register value}
  localparam logic [15:0] VEC [0:NVEC-1] = '{
    16'h20C0, 16'h08D0, 16'h04E0, 16'h02F0, 16'h2040, 16'h0080, 16'h0000
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic pg = 1'b1, ps = 1'b1, slow_clk = 1'b0;
  logic tick_gen = 1'b0, tick_man = 1'b0, we = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic ref_req, ref_cbr, tb_slow, pd_act;
  logic slow_en = 1'b1, tick_en = 1'b1;
  int sc_cnt = 0, ft_cnt = 0, req_cnt = 0;
  logic last_cbr = 1'b0;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  stby_refresh_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .pwr_good_i(pg), .pwr_sense_i(ps),
    .slow_clk_i(slow_clk), .fast_tick_i(tick_gen | tick_man),
    .cfg_we_i(we), .cfg_wdata_i(wdata), .cfg_rdata_o(rdata),
    .ref_req_o(ref_req), .ref_cbr_o(ref_cbr), .tb_slow_o(tb_slow),
    .pd_active_o(pd_act)
  );

  always @(negedge clk) begin
    if (slow_en) begin
      if (sc_cnt == SLOW_HALF - 1) begin sc_cnt <= 0; slow_clk <= ~slow_clk; end
      else sc_cnt <= sc_cnt + 1;
    end
    if (tick_en) begin
      ft_cnt   <= (ft_cnt == FT_PER - 1) ? 0 : ft_cnt + 1;
      tick_gen <= (ft_cnt == FT_PER - 1);
    end else tick_gen <= 1'b0;
    if (ref_req) begin req_cnt <= req_cnt + 1; last_cbr <= ref_cbr; end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic near(input string req, input int act, input int exp);
    chk((exp == 0) ? (act == 0) : (act >= exp - 1 && act <= exp + 1), req, act, exp);
  endtask

  task automatic wr(input logic [7:0] v);
    @(negedge clk); we = 1'b1; wdata = v;
    @(negedge clk); we = 1'b0;
    wait_clk(2);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual 0 expected 1");
    finish_run();
  end

  initial begin
    wait_clk(3); rst_n = 1'b1; wait_clk(10);
    // R1 reset state
    chk(rdata == 8'h00, "R1", rdata, 0);
    chk(!tb_slow && !pd_act, "R1", {tb_slow, pd_act}, 0);
    chk(req_cnt == 0, "R1", req_cnt, 0);

    for (int i = 0; i < NVEC; i++) begin
      logic [7:0] cv; int ex; int c0;
      cv = VEC[i][7:0]; ex = int'(VEC[i][15:8]);
      wr(cv);
      chk(rdata == cv, "R2", rdata, cv);
      c0 = req_cnt; wait_clk(300);
      near("R3", req_cnt - c0, 10);
      chk(last_cbr == cv[7], "R3", last_cbr, cv[7]);
      pg = 1'b0; wait_clk(100);
      chk(pd_act == 1'b1, cv[6] ? "R5" : "R4", pd_act, 1);
      chk(tb_slow == cv[6], "R5", tb_slow, cv[6]);
      c0 = req_cnt; wait_clk(32 * SLOW_HALF);
      near(cv[6] ? "R6" : "R4", req_cnt - c0, ex);
      chk(rdata[7:4] == cv[7:4], "R7", rdata[7:4], cv[7:4]);
      pg = 1'b1; wait_clk(100);
      chk(!tb_slow && !pd_act, "R8", {tb_slow, pd_act}, 0);
    end

    // R2 reserved and read-only bits
    wr(8'hFF);
    chk(rdata == 8'hF0, "R2", rdata, 8'hF0);
    wr(8'h00);
    // R2 write ignored while power-good low
    pg = 1'b0; wait_clk(20);
    wr(8'hF0);
    pg = 1'b1; wait_clk(20);
    chk(rdata == 8'h00, "R2", rdata, 0);

    // R7 sense clear during standby
    wr(8'hC0);
    pg = 1'b0; wait_clk(100);
    ps = 1'b0; wait_clk(20);
    chk(rdata == 8'h00, "R7", rdata, 0);
    chk(pd_act && !tb_slow, "R7", {pd_act, tb_slow}, 2);
    ps = 1'b1; pg = 1'b1; wait_clk(50);
    chk(rdata == 8'h00, "R7", rdata, 0);

    // R5 hand-over waits for a slow edge
    wr(8'hC0);
    slow_en = 1'b0;
    begin
      int c0;
      pg = 1'b0; c0 = req_cnt; wait_clk(300);
      chk(!pd_act && !tb_slow, "R5", {pd_act, tb_slow}, 0);
      near("R5", req_cnt - c0, 10);
    end
    slow_en = 1'b1; wait_clk(100);
    chk(pd_act && tb_slow, "R5", {pd_act, tb_slow}, 3);
    pg = 1'b1; wait_clk(100);

    // R8 recovery holds slow timebase at full rate
    wr(8'hF0);
    pg = 1'b0; wait_clk(100);
    tick_en = 1'b0;
    pg = 1'b1; wait_clk(100);
    chk(tb_slow && !pd_act, "R8", {tb_slow, pd_act}, 2);
    begin
      int c0;
      c0 = req_cnt; wait_clk(16 * SLOW_HALF);
      near("R8", req_cnt - c0, 16);
    end
    @(negedge clk); tick_man = 1'b1; @(negedge clk); tick_man = 1'b0;
    wait_clk(10);
    chk(!tb_slow, "R8", tb_slow, 0);
    chk(rdata[6] == 1'b1, "R8", rdata[6], 1);

    // R9 watchdog
    pg = 1'b0; wait_clk(100);
    pg = 1'b1; wait_clk(2000);
    chk(tb_slow && rdata[6], "R9", {tb_slow, rdata[6]}, 3);
    wait_clk(800);
    chk(!tb_slow, "R9", tb_slow, 0);
    chk(rdata[6] == 1'b0, "R9", rdata[6], 0);
    tick_en = 1'b1; wait_clk(50);

    finish_run();
  end
endmodule